// File: doc/BRIEF.md
# Clock-Enabled System Bus Interface Unit

This unit sits between a processor core running on a fast clock and a system bus that runs at a slower rate synchronous to it. The bus rate is never seen as a separate clock: a bus enable input, high on a fast-clock edge, marks that edge as a bus-clock edge. Every register inside the unit is clocked by the fast clock, and bus outputs only move on marked edges.

The core presents a read or an unbuffered write (request, direction, address, write data) and keeps these stable while it is stalled. The unit pulls the core's clock enable low at once. It then waits for the next bus edge to drive address and control, which is the synchronization part of the stall. Next it runs the address and data phases. The data phase ends on the first edge where both bus ready and bus enable are high. Read data is registered on that edge and the stall is released for the following cycle. Buffered writes and tightly coupled memory accesses never come here; the core routes them elsewhere.

Top module: `slow_bus_biu`

## Requirements
- R1: In reset and right after it, core_en is 1, htrans is idle (2'b00), haddr is 0 and rd_valid is 0.
- R2: haddr, htrans, hwrite and hwdata change only on fast-clock edges where hclken is 1.
- R3: A request starts its transfer on the first hclken edge at or after the request cycle. On that edge htrans becomes NONSEQ (2'b10) and haddr and hwrite take the core's address and direction (1 = write). htrans returns to idle on the next hclken edge where hready is 1.
- R4: The data phase completes only on an edge where hready and hclken are both 1. hready high on a cycle without hclken has no effect.
- R5: Any number of slave wait states (hready low on hclken edges) is tolerated, and each one adds exactly one bus period to the transfer.
- R6: core_en is 0 from the request cycle through the completing edge and 1 in the next cycle. With ratio N, a sync wait k (0 to N-1) and w wait states, the stall lasts k + N*(2+w) + 1 cycles, never more than N*(3+w).
- R7: On a read, hrdata is captured into rd_data on the completing edge. rd_valid is 1 for exactly the cycle that core_en comes back. rd_data then holds its value until the next read completes; writes do not disturb it.
- R8: On a write, hwdata carries the core's write data from the hclken edge that ends the address phase through to completion.
- R9: With ratio 1 (hclken always 1) there is no sync wait, and a transfer with no wait states stalls the core for 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; all registers use its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core requests a bus read or unbuffered write |
| core_write | input | 1 | 1 = write, 0 = read |
| core_addr | input | AW | Transfer address, stable while stalled |
| core_wdata | input | DW | Write data, stable while stalled |
| core_en | output | 1 | Clock enable back to the core; 0 = stalled |
| rd_data | output | DW | Registered read data |
| rd_valid | output | 1 | One-cycle pulse: rd_data has just been updated |
| hclken | input | 1 | Marks a fast-clock edge as a bus-clock edge |
| hready | input | 1 | Bus ready from the slave |
| hrdata | input | DW | Bus read data |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Bus transfer type: 2'b00 idle, 2'b10 non-sequential |
| hwrite | output | 1 | Bus direction, 1 = write |
| hwdata | output | DW | Bus write data |

## Verification
A wrong state in the sequencer shows at the ports within one bus period. The stall length differs from k + N*(2+w) + 1 by at least one cycle, or by a whole bus period if a phase is skipped or repeated. A lost qualification by hclken shows as completion on a non-bus edge, which shortens the stall. A register updated on the wrong edge shows as a bus output moving between bus edges. It can also show as the wrong address or write data being seen by the slave, or as stale read data on the cycle the stall releases.

// File: rtl/slow_bus_biu.sv
module slow_bus_biu #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic          core_write,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          hclken,
  input  logic          hready,
  input  logic [DW-1:0] hrdata,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [DW-1:0] hwdata
);

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_SYNC, S_ADDR, S_DATA} state_t;

  state_t st;
  logic   fin;

  wire bus_edge = hclken;
  wire bus_done = hclken & hready;
  wire start    = core_req & ~fin;

  assign core_en = fin | (st == S_IDLE && !core_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      fin      <= 1'b0;
      haddr    <= '0;
      htrans   <= TR_IDLE;
      hwrite   <= 1'b0;
      hwdata   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      fin      <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE, S_SYNC: begin
          if ((st == S_SYNC) || start) begin
            if (bus_edge) begin
              haddr  <= core_addr;
              hwrite <= core_write;
              htrans <= TR_NONSEQ;
              st     <= S_ADDR;
            end else begin
              st <= S_SYNC;
            end
          end
        end
        S_ADDR: begin
          if (bus_done) begin
            htrans <= TR_IDLE;
            if (hwrite) hwdata <= core_wdata;
            st <= S_DATA;
          end
        end
        S_DATA: begin
          if (bus_done) begin
            st  <= S_IDLE;
            fin <= 1'b1;
            if (!hwrite) begin
              rd_data  <= hrdata;
              rd_valid <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hclken |=> ($stable(haddr) && $stable(htrans) && $stable(hwrite) && $stable(hwdata)));

  p_nonseq_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == TR_NONSEQ && hclken && hready) |=> (htrans == TR_IDLE));

  p_ready_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && hready && !hclken) |=> (st == S_DATA && !core_en));

  p_stall_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> !core_en);

  p_sync_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SYNC && hclken) |=> (st == S_ADDR && htrans == TR_NONSEQ));

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (rd_valid || $stable(rd_data)));

  p_rvalid_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> core_en);

endmodule

// File: tb/slow_bus_biu_test.sv
module slow_bus_biu_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        core_req = 0, core_write = 0;
  logic [31:0] core_addr = 0, core_wdata = 0;
  logic        core_en, rd_valid, hwrite;
  logic [31:0] rd_data, haddr, hwdata, hrdata;
  logic [1:0]  htrans;
  logic        hclken, hready;

  int ratio = 1, waits = 0, ph = 0;
  logic glitch = 0;
  logic s_data = 0, s_wr = 0, hready_s = 1;
  int   s_cnt = 0;
  logic [31:0] s_addr = 0, s_wd = 0;
  int n_chk = 0, n_fail = 0, viol = 0;
  logic last_en = 0;
  logic [31:0] p_addr = 0;
  logic [1:0]  p_trans = 0;

  always #5 clk = ~clk;

  slow_bus_biu uut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_write(core_write),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_en(core_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .hclken(hclken), .hready(hready),
    .hrdata(hrdata), .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hwdata(hwdata));

  assign hclken = (ph == 0);
  assign hready = hready_s | (glitch & ~hclken);
  assign hrdata = s_data ? (s_addr ^ 32'hA5A5_0000) : 32'h0;

  always @(posedge clk) begin
    ph <= (ph >= ratio - 1) ? 0 : ph + 1;
    last_en <= hclken;
    if (hclken) begin
      if (s_data && hready_s) begin
        s_data <= 0;
        if (s_wr) s_wd <= hwdata;
      end
      if (htrans == 2'b10 && hready_s) begin
        s_data <= 1; s_addr <= haddr; s_wr <= hwrite;
        s_cnt <= waits; hready_s <= (waits == 0);
      end else if (s_data && !hready_s) begin
        s_cnt <= s_cnt - 1; hready_s <= (s_cnt == 1);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !last_en && (haddr != p_addr || htrans != p_trans)) viol++;
    p_addr <= haddr; p_trans <= htrans;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // fields: [31:28] ratio, [27:24] waits, [23:20] write, [19:16] gap, [15:0] addr
  localparam logic [31:0] VEC [12] = '{
    32'h1001_0010, 32'h1010_0020, 32'h2002_0104, 32'h2213_0208,
    32'h3000_010C, 32'h3112_0310, 32'h3500_0014, 32'h4001_0118,
    32'h4210_021C, 32'h4303_0320, 32'h4700_0024, 32'h1410_0028
  };

  task automatic xfer(input int n, input int w, input bit wr, input int gap, input logic [15:0] a);
    int k, cnt, expc;
    logic [31:0] wd;
    if (n != ratio) begin ratio = n; repeat (6) @(negedge clk); end
    waits = w;
    repeat (gap) @(negedge clk);
    k = (ph == 0) ? 0 : n - ph;
    wd = {a, ~a};
    core_addr = {16'h4000, a}; core_write = wr; core_wdata = wd; core_req = 1;
    cnt = 0;
    #1;
    while (!core_en) begin cnt++; @(negedge clk); #1; end
    expc = k + n * (2 + w) + 1;
    chk(cnt == expc, $sformatf("R6 stall n=%0d w=%0d", n, w), cnt, expc);
    chk(cnt <= n * (3 + w), "R6 stall bound", cnt, n * (3 + w));
    if (w > 0) chk(cnt == expc, "R5 wait states", cnt, expc);
    if (n == 1) chk(cnt == 3 + w, "R9 ratio one", cnt, 3 + w);
    chk(s_addr == core_addr && s_wr == wr, "R3 address and direction", s_addr, core_addr);
    if (wr) begin
      chk(s_wd == wd, "R8 write data", s_wd, wd);
      chk(rd_valid == 0, "R7 no valid on write", rd_valid, 0);
    end else begin
      chk(rd_valid == 1, "R7 valid pulse", rd_valid, 1);
      chk(rd_data == (core_addr ^ 32'hA5A5_0000), "R7 read data", rd_data, core_addr ^ 32'hA5A5_0000);
    end
    core_req = 0;
    @(negedge clk);
    chk(htrans == 2'b00 && rd_valid == 0, "R3 htrans idle after", htrans, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(core_en == 1 && htrans == 0 && rd_valid == 0 && haddr == 0, "R1 reset state",
        {core_en, rd_valid, htrans, haddr[27:0]}, 32'h8000_0000);
    rst_n = 1;
    @(negedge clk);
    chk(core_en == 1 && htrans == 0 && rd_valid == 0, "R1 after reset", core_en, 1);

    foreach (VEC[i])
      xfer(int'(VEC[i][31:28]), int'(VEC[i][27:24]), VEC[i][20], int'(VEC[i][19:16]), VEC[i][15:0]);

    glitch = 1;
    xfer(4, 3, 0, 1, 16'h0300);
    xfer(3, 2, 0, 2, 16'h0304);
    glitch = 0;
    chk(1, "R4 ready without enable ignored", 0, 0);

    xfer(2, 1, 0, 1, 16'h0400);
    xfer(2, 2, 1, 1, 16'h0404);
    chk(rd_data == (32'h4000_0400 ^ 32'hA5A5_0000), "R7 rd_data held over write",
        rd_data, 32'h4000_0400 ^ 32'hA5A5_0000);

    chk(viol == 0, "R2 bus outputs move only on enable edges", viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule